// File: doc/BRIEF.md
# Reset Sequencer with Write Lockout

This block conditions the active-low reset pin of a memory-based peripheral. A power-good flag marks stable supply. The block tells the first reset after power-up apart from every later warm reset and asks each kind for its own minimum low-pulse length. Pulses that are too short are ignored. Once a valid pulse ends, the internal reset stays asserted for a fixed operational delay, and only then is access allowed. During the power-on phase the block asks for the configuration load and register clear. When a reset sequence completes, it forces the memory into read mode for one cycle.

The block also filters raw write strobes. For a guard window after power-good rises, no strobe reaches the nonvolatile array. While the low-voltage lockout flag is set, no new write may start. A strobe may pass only if it rises while writes are allowed. Once a strobe is passing, it keeps passing until it falls. Every cycle count is a parameter.

Top module: `rstseq_wlock`

## Requirements
- R1: While `pwr_ok` is low, `int_rst` is 1 and `acc_rdy`, `cfg_load_req`, `rd_mode_force` and `wr_gated` are all 0.
- R2: The reset pin passes through a two-flop synchronizer. The first reset after `pwr_ok` rises is accepted only after at least POR_MIN_CYC consecutive synchronized low samples. A shorter low pulse leaves `int_rst` at 1 with no release.
- R3: After the first completed sequence, a low run of at least WARM_MIN_CYC synchronized samples asserts `int_rst` and is accepted as a warm reset. A shorter low run while running leaves `int_rst` at 0.
- R4: The synchronized pin is first seen high after a valid pulse. The cycle after that, a delay of OPR_DLY_CYC cycles starts, and `int_rst` falls when it ends. Any synchronized low during the delay returns the block to waiting for a valid pulse.
- R5: `cfg_load_req` is 1 from the first cycle with `pwr_ok` high until the first sequence completes. It stays 0 through warm resets.
- R6: `rd_mode_force` is a one-cycle pulse in the first cycle in which `int_rst` is 0 after each completed sequence.
- R7: `acc_rdy` is 1 exactly when `int_rst` is 0 and configuration loading has finished.
- R8: For GUARD_CYC cycles after `pwr_ok` rises, `wr_gated` is all zero whatever `wr_raw` does.
- R9: While `lvlo` is 1, no bit of `wr_gated` rises. A bit that was already passing keeps passing while its raw strobe stays high.
- R10: A raw strobe bit that is already high when writes become allowed stays blocked until it falls and rises again. Bit i of `wr_gated` never rises unless bit i of `wr_raw` rises in the same cycle.
- R11: A drop of `pwr_ok` clears the completed-power-on state. The next reset again needs the POR_MIN_CYC length, the guard window restarts and `cfg_load_req` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Supply stable flag; low acts as synchronous reset |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| lvlo | input | 1 | Low-voltage lockout flag |
| wr_raw | input | WR_W | Raw write strobes |
| int_rst | output | 1 | Internal reset, active high |
| acc_rdy | output | 1 | Memory access allowed |
| wr_gated | output | WR_W | Write strobes toward the array |
| cfg_load_req | output | 1 | Configuration load and register clear request |
| rd_mode_force | output | 1 | One-cycle pulse forcing read mode |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the end of the guard window and a strobe that is already high. The second pair is the lockout flag falling while a strobe is held. The bench holds a strobe across the guard expiry and across the lockout release, and it expects no output until the strobe rises again. A behavioural model is compared with every output on every clock. That comparison also judges a warm pulse that lands during the post-release delay, where the abort and the delay expiry compete.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,
        PH_DELAY = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        logic int_rst;
        logic por_done;
        logic rd_force;
    } seq_out_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsq_pin_meter.sv
module rsq_pin_meter #(
    parameter int unsigned MAX_RUN = 2000,
    localparam int unsigned CW = $clog2(MAX_RUN + 1)
) (
    input  logic          clk,
    input  logic          pwr_ok,
    input  logic          rst_pin_n,
    output logic          pin_low,
    output logic [CW-1:0] low_run
);
    localparam logic [CW-1:0] RUN_CAP = CW'(MAX_RUN);

    logic s1, s2;

    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            low_run <= '0;
        end else begin
            s1 <= rst_pin_n;
            s2 <= s1;
            if (!s2) begin
                if (low_run != RUN_CAP) low_run <= low_run + 1'b1;
            end else begin
                low_run <= '0;
            end
        end
    end

    assign pin_low = ~s2;

endmodule

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
    import rsq_pkg::*;
#(
    parameter int unsigned POR_MIN_CYC  = 2000,
    parameter int unsigned WARM_MIN_CYC = 200,
    parameter int unsigned OPR_DLY_CYC  = 150,
    parameter int unsigned CW           = 11,
    localparam int unsigned DW = $clog2(OPR_DLY_CYC + 1)
) (
    input  logic          clk,
    input  logic          pwr_ok,
    input  logic          pin_low,
    input  logic [CW-1:0] low_run,
    output seq_out_t      st
);
    localparam logic [CW-1:0] POR_L   = CW'(POR_MIN_CYC);
    localparam logic [CW-1:0] WARM_L  = CW'(WARM_MIN_CYC);
    localparam logic [CW-1:0] WARM_M1 = CW'(WARM_MIN_CYC - 1);
    localparam logic [DW-1:0] DLY_END = DW'(OPR_DLY_CYC - 1);

    phase_e        phase;
    logic [DW-1:0] dly;
    logic          por_done;
    logic          rd_force;
    logic [CW-1:0] need_len;

    assign need_len = por_done ? WARM_L : POR_L;

    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            phase    <= PH_HOLD;
            dly      <= '0;
            por_done <= 1'b0;
            rd_force <= 1'b0;
        end else begin
            rd_force <= 1'b0;
            unique case (phase)
                PH_HOLD: begin
                    if (!pin_low && (low_run >= need_len)) begin
                        phase <= PH_DELAY;
                        dly   <= '0;
                    end
                end
                PH_DELAY: begin
                    if (pin_low) begin
                        phase <= PH_HOLD;
                    end else if (dly == DLY_END) begin
                        phase    <= PH_RUN;
                        por_done <= 1'b1;
                        rd_force <= 1'b1;
                    end else begin
                        dly <= dly + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (pin_low && (low_run >= WARM_M1)) phase <= PH_HOLD;
                end
                default: phase <= PH_HOLD;
            endcase
        end
    end

    always_comb begin
        st.int_rst  = (phase != PH_RUN);
        st.por_done = por_done;
        st.rd_force = rd_force;
    end

endmodule

// File: rtl/rsq_wr_gate.sv
module rsq_wr_gate #(
    parameter int unsigned WR_W      = 2,
    parameter int unsigned GUARD_CYC = 625000,
    localparam int unsigned GW = $clog2(GUARD_CYC + 1)
) (
    input  logic            clk,
    input  logic            pwr_ok,
    input  logic            lvlo,
    input  logic [WR_W-1:0] wr_raw,
    output logic [WR_W-1:0] wr_gated
);
    localparam logic [GW-1:0] GUARD_L = GW'(GUARD_CYC);

    logic [GW-1:0]   guard_cnt;
    logic [WR_W-1:0] raw_q;
    logic [WR_W-1:0] pass_q;
    logic            allow;

    always_ff @(posedge clk) begin
        if (!pwr_ok) begin
            guard_cnt <= '0;
            raw_q     <= '0;
            pass_q    <= '0;
        end else begin
            if (guard_cnt != GUARD_L) guard_cnt <= guard_cnt + 1'b1;
            raw_q  <= wr_raw;
            pass_q <= wr_gated;
        end
    end

    assign allow = (guard_cnt == GUARD_L) && !lvlo;

    for (genvar i = 0; i < WR_W; i++) begin : g_bit
        assign wr_gated[i] = wr_raw[i] & (pass_q[i] | (allow & ~raw_q[i]));
    end

endmodule

// File: rtl/rstseq_wlock.sv
module rstseq_wlock
    import rsq_pkg::*;
#(
    parameter int unsigned POR_MIN_CYC  = 2000,
    parameter int unsigned WARM_MIN_CYC = 200,
    parameter int unsigned OPR_DLY_CYC  = 150,
    parameter int unsigned GUARD_CYC    = 625000,
    parameter int unsigned WR_W         = 2
) (
    input  logic            clk,
    input  logic            pwr_ok,
    input  logic            rst_pin_n,
    input  logic            lvlo,
    input  logic [WR_W-1:0] wr_raw,
    output logic            int_rst,
    output logic            acc_rdy,
    output logic [WR_W-1:0] wr_gated,
    output logic            cfg_load_req,
    output logic            rd_mode_force
);
    localparam int unsigned MAX_RUN = max_u(POR_MIN_CYC, WARM_MIN_CYC);
    localparam int unsigned CW      = $clog2(MAX_RUN + 1);

    logic          pin_low;
    logic [CW-1:0] low_run;
    seq_out_t      st;

    rsq_pin_meter #(.MAX_RUN(MAX_RUN)) u_meter (
        .clk       (clk),
        .pwr_ok    (pwr_ok),
        .rst_pin_n (rst_pin_n),
        .pin_low   (pin_low),
        .low_run   (low_run)
    );

    rsq_phase_fsm #(
        .POR_MIN_CYC  (POR_MIN_CYC),
        .WARM_MIN_CYC (WARM_MIN_CYC),
        .OPR_DLY_CYC  (OPR_DLY_CYC),
        .CW           (CW)
    ) u_fsm (
        .clk     (clk),
        .pwr_ok  (pwr_ok),
        .pin_low (pin_low),
        .low_run (low_run),
        .st      (st)
    );

    rsq_wr_gate #(.WR_W(WR_W), .GUARD_CYC(GUARD_CYC)) u_gate (
        .clk      (clk),
        .pwr_ok   (pwr_ok),
        .lvlo     (lvlo),
        .wr_raw   (wr_raw),
        .wr_gated (wr_gated)
    );

    assign int_rst       = st.int_rst;
    assign acc_rdy       = !st.int_rst && st.por_done;
    assign cfg_load_req  = pwr_ok && !st.por_done;
    assign rd_mode_force = st.rd_force;

endmodule

// File: rtl/rstseq_wlock_chk.sv
module rstseq_wlock_chk #(
    parameter int unsigned GUARD_CYC = 625000,
    parameter int unsigned WR_W      = 2
) (
    input logic            clk,
    input logic            pwr_ok,
    input logic            rst_pin_n,
    input logic            lvlo,
    input logic [WR_W-1:0] wr_raw,
    input logic            int_rst,
    input logic            acc_rdy,
    input logic [WR_W-1:0] wr_gated,
    input logic            cfg_load_req,
    input logic            rd_mode_force
);
    int unsigned since_pwr;

    always_ff @(posedge clk) begin
        if (!pwr_ok) since_pwr <= 0;
        else if (since_pwr < GUARD_CYC) since_pwr <= since_pwr + 1;
    end

    // R7
    a_r7_ready_needs_release: assert property (@(posedge clk) disable iff (!pwr_ok)
        acc_rdy |-> !int_rst);

    // R5
    a_r5_load_blocks_ready: assert property (@(posedge clk) disable iff (!pwr_ok)
        cfg_load_req |-> !acc_rdy);

    // R6
    a_r6_force_at_release: assert property (@(posedge clk) disable iff (!pwr_ok)
        rd_mode_force |-> $fell(int_rst));

    // R8
    a_r8_guard_window: assert property (@(posedge clk) disable iff (!pwr_ok)
        (since_pwr < GUARD_CYC) |-> (wr_gated == '0));

    // R9
    a_r9_no_start_in_lockout: assert property (@(posedge clk) disable iff (!pwr_ok)
        lvlo |-> ((wr_gated & ~$past(wr_gated)) == '0));

    // R10
    a_r10_gated_within_raw: assert property (@(posedge clk) disable iff (!pwr_ok)
        ((wr_gated & ~$past(wr_gated) & ~(wr_raw & ~$past(wr_raw))) == '0));

endmodule

bind rstseq_wlock rstseq_wlock_chk #(.GUARD_CYC(GUARD_CYC), .WR_W(WR_W)) u_chk (.*);

// File: tb/rstseq_wlock_bench.sv
module rstseq_wlock_bench;
    localparam int POR  = 20;
    localparam int WARM = 5;
    localparam int OPR  = 6;
    localparam int G    = 40;
    localparam int W    = 2;
    localparam int MAXL = (POR > WARM) ? POR : WARM;

    logic clk = 1'b0;
    logic pwr_ok = 1'b0, rst_pin_n = 1'b1, lvlo = 1'b0;
    logic [W-1:0] wr_raw = '0;
    logic int_rst, acc_rdy, cfg_load_req, rd_mode_force;
    logic [W-1:0] wr_gated;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0, finished = 0;

    // behavioural reference state
    int m_s1 = 1, m_s2 = 1, m_low = 0, m_ph = 0, m_dly = 0, m_por = 0, m_force = 0, m_guard = 0;
    logic [W-1:0] m_rawq = '0, m_passq = '0;

    rstseq_wlock #(.POR_MIN_CYC(POR), .WARM_MIN_CYC(WARM), .OPR_DLY_CYC(OPR),
                   .GUARD_CYC(G), .WR_W(W)) u_rstseq_wlock (
        .clk(clk), .pwr_ok(pwr_ok), .rst_pin_n(rst_pin_n), .lvlo(lvlo), .wr_raw(wr_raw),
        .int_rst(int_rst), .acc_rdy(acc_rdy), .wr_gated(wr_gated),
        .cfg_load_req(cfg_load_req), .rd_mode_force(rd_mode_force));

    always #4 clk = ~clk;

    function automatic logic [W-1:0] exp_wr();
        logic allow;
        allow = (m_guard == G) && !lvlo;
        return wr_raw & (m_passq | ({W{allow}} & ~m_rawq));
    endfunction

    always @(posedge clk) begin
        int minreq, pl;
        logic [W-1:0] g_now;
        cyc++;
        started = 1;
        if (!pwr_ok) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_ph = 0; m_dly = 0;
            m_por = 0; m_force = 0; m_guard = 0; m_rawq = '0; m_passq = '0;
        end else begin
            g_now  = exp_wr();
            pl     = (m_s2 == 0);
            minreq = m_por ? WARM : POR;
            m_force = 0;
            case (m_ph)
                0: if (!pl && m_low >= minreq) begin m_ph = 1; m_dly = 0; end
                1: if (pl) m_ph = 0;
                   else if (m_dly == OPR - 1) begin m_ph = 2; m_por = 1; m_force = 1; end
                   else m_dly++;
                default: if (pl && m_low >= WARM - 1) m_ph = 0;
            endcase
            m_low   = pl ? ((m_low < MAXL) ? m_low + 1 : MAXL) : 0;
            m_passq = g_now;
            m_rawq  = wr_raw;
            if (m_guard < G) m_guard++;
            m_s2 = m_s1;
            m_s1 = rst_pin_n;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // per-cycle comparison, 1 ns before the rising edge
    always @(negedge clk) begin
        #3;
        if (started && !finished) begin
            cmp("R4 int_rst", int_rst, (m_ph != 2));
            cmp("R7 acc_rdy", acc_rdy, (m_ph == 2) && (m_por != 0));
            cmp("R5 cfg_load_req", cfg_load_req, pwr_ok && (m_por == 0));
            cmp("R6 rd_mode_force", rd_mode_force, m_force);
            cmp("R10 wr_gated", int'(wr_gated), int'(exp_wr()));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic probe(input string tag, input int act, input int exp);
        cmp(tag, act, exp);
    endtask

    initial begin
        wait_cyc(5);
        #3;
        probe("R1 int_rst held", int_rst, 1);
        probe("R1 acc_rdy low", acc_rdy, 0);
        probe("R1 cfg_load_req low", cfg_load_req, 0);
        probe("R1 wr_gated low", int'(wr_gated), 0);
        wait_cyc(1);
        // power-up with a too-short first pulse
        pwr_ok = 1; wr_raw = 2'b10; rst_pin_n = 0;
        wait_cyc(3); #3;
        probe("R8 guard blocks strobe", int'(wr_gated), 0);
        probe("R5 load requested", cfg_load_req, 1);
        wait_cyc(7); rst_pin_n = 1;
        wait_cyc(10); #3;
        probe("R2 short first pulse ignored", int_rst, 1);
        wait_cyc(1);
        rst_pin_n = 0; wait_cyc(25); rst_pin_n = 1;
        wait_cyc(15); #3;
        probe("R4 released after delay", int_rst, 0);
        probe("R7 access ready", acc_rdy, 1);
        probe("R5 load finished", cfg_load_req, 0);
        probe("R10 held strobe stays blocked", int'(wr_gated), 0);
        wait_cyc(1);
        wr_raw = 2'b00; wait_cyc(1); wr_raw = 2'b10; wait_cyc(1); #3;
        probe("R10 fresh rise passes", int'(wr_gated), 2);
        wait_cyc(1);
        wr_raw = 2'b00;
        // lockout
        lvlo = 1; wait_cyc(1); wr_raw = 2'b01; wait_cyc(2); #3;
        probe("R9 no start under lockout", int'(wr_gated), 0);
        wait_cyc(1);
        lvlo = 0; wait_cyc(2); #3;
        probe("R10 strobe held across lockout stays blocked", int'(wr_gated), 0);
        wait_cyc(1);
        wr_raw = 2'b00; wait_cyc(1); wr_raw = 2'b01; wait_cyc(1); #3;
        probe("R9 start allowed without lockout", int'(wr_gated), 1);
        wait_cyc(1);
        lvlo = 1; wait_cyc(2); #3;
        probe("R9 running write continues", int'(wr_gated), 1);
        wait_cyc(1);
        wr_raw = 2'b00; lvlo = 0; wait_cyc(2);
        // warm resets
        rst_pin_n = 0; wait_cyc(3); rst_pin_n = 1; wait_cyc(8); #3;
        probe("R3 short warm glitch ignored", int_rst, 0);
        wait_cyc(1);
        rst_pin_n = 0; wait_cyc(9); #3;
        probe("R3 warm pulse asserts reset", int_rst, 1);
        wait_cyc(1);
        rst_pin_n = 1; wait_cyc(12); #3;
        probe("R3 warm release", int_rst, 0);
        probe("R5 no load on warm reset", cfg_load_req, 0);
        wait_cyc(1);
        // low during the post-release delay
        rst_pin_n = 0; wait_cyc(8); rst_pin_n = 1; wait_cyc(3);
        rst_pin_n = 0; wait_cyc(8); rst_pin_n = 1; wait_cyc(12); #3;
        probe("R4 abort then release", int_rst, 0);
        wait_cyc(1);
        // power loss
        pwr_ok = 0; wait_cyc(2); #3;
        probe("R11 power loss resets", int_rst, 1);
        probe("R1 ready low on power loss", acc_rdy, 0);
        wait_cyc(1);
        pwr_ok = 1; wr_raw = 2'b01; rst_pin_n = 0;
        wait_cyc(2); #3;
        probe("R8 guard restarted", int'(wr_gated), 0);
        wait_cyc(1);
        wr_raw = 2'b00; wait_cyc(5); rst_pin_n = 1; wait_cyc(15); #3;
        probe("R11 warm length no longer enough", int_rst, 1);
        probe("R11 load requested again", cfg_load_req, 1);
        wait_cyc(1);
        rst_pin_n = 0; wait_cyc(25); rst_pin_n = 1; wait_cyc(15); #3;
        probe("R11 power-on release", int_rst, 0);
        probe("R7 ready after reload", acc_rdy, 1);
        wait_cyc(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog cycle %0d actual=running expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule